// File: doc/BRIEF.md
# Pairwise Selection, Crossover and Mutation Engine

This block turns an evaluated sub-population of binary chromosomes into offspring, two at a time. Each operation picks two parents by fitness through an external combinational read port into population storage. It can recombine the two parents at random cut points and then sends each child through its own bit-flip mutator. It emits both children in one output beat, together with the indices of the parents it chose. All randomness comes from one internal 32-bit xorshift generator. Software can reseed that generator, and the crossover and mutation probabilities are live inputs, so neither needs a rebuild.

The parent-picking method is a build parameter: tournament (1) or fitness-proportional roulette (0). The number of cut points is also a build parameter: one gives single-point exchange, more give multi-point exchange. A generation of `POP_SIZE` individuals needs `POP_SIZE/2` operations. When `POP_SIZE/2` copies of the engine run side by side, a generation's offspring are produced in a single pass.

Top module: `scm_pair_unit`

## Requirements
- R1: After reset, `busy` and `off_valid` are low. The generator state equals 0x2545F491.
- R2: The generator step is x ^= x<<13, then x ^= x>>17, then x ^= x<<5. Each draw advances the state once and uses the new state as the 32-bit value. A `seed_load` pulse loads `seed`, and a zero seed loads 0x2545F491 instead.
- R3: One operation draws in this fixed order: parent A selection, parent B selection, one crossover decision, `NUM_CUTS` cut draws (always taken), and `CHROM_W` mutation draws for bits 0 upward. Parent A's chromosome is read before parent B is selected.
- R4: Tournament (SEL_METHOD=1) takes two draws. The low log2(POP_SIZE) bits of each give candidates i and then j. The candidate with the higher fitness wins, and on equal fitness the lower index wins.
- R5: Roulette (SEL_METHOD=0) sums all fitness values into T. It then takes one draw r and forms target = (r[15:0]*T)>>16. It picks the first index whose running prefix sum exceeds the target, or index POP_SIZE-1 if none does, so an all-zero population picks the last index.
- R6: Crossover fires when the decision draw's bits [15:0] are below `xover_rate`. When it does not fire, the children equal parents A and B before mutation, so a rate of 0 never recombines.
- R7: Cut k is the low log2(CHROM_W) bits of its draw. The mask is the XOR over all cuts of (1<<cut)-1. Child A takes A's bits where the mask is 1 and B's bits elsewhere, and child B takes the complement. Without mutation, the children carry exactly the parents' bits: (A^B) and (A&B) are preserved.
- R8: For bit k, the draw's bits [15:0] flip child A's bit k if they are below `mut_rate`. The draw's bits [31:16] flip child B's bit k under the same test. A rate of 0 leaves both children unchanged.
- R9: `off_valid` is a one-cycle pulse that carries both children and both parent indices. `busy` stays high from the cycle after `start` through that pulse. A `start` while `busy` is high is ignored and consumes no draws.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one pair operation when idle |
| busy | output | 1 | Operation in progress |
| seed_load | input | 1 | Load generator seed |
| seed | input | 32 | Seed value (zero replaced by a fixed constant) |
| xover_rate | input | RATE_W | Crossover probability as a 16-bit fraction |
| mut_rate | input | RATE_W | Per-bit flip probability as a 16-bit fraction |
| rd_addr | output | log2(POP_SIZE) | Population read index |
| rd_chrom | input | CHROM_W | Chromosome at `rd_addr` (same cycle) |
| rd_fit | input | FIT_W | Fitness at `rd_addr` (same cycle) |
| off_valid | output | 1 | Offspring beat valid |
| off_idx_a | output | log2(POP_SIZE) | Index of parent A |
| off_idx_b | output | log2(POP_SIZE) | Index of parent B |
| off_child_a | output | CHROM_W | First offspring |
| off_child_b | output | CHROM_W | Second offspring |

## Verification
Every random choice is drawn from a single generator in a fixed order. A wrong generator state, an extra draw or a skipped draw therefore shows up as wrong parent indices or wrong children in the very next offspring beat, and it carries into every later beat. A selector fault shows at once in `off_idx_a`/`off_idx_b`. A mask or mutator fault shows in the children of the same beat. Directed cases with zero rates, a single nonzero fitness, equal fitness and an all-zero population isolate the selection rules, because there the expected indices or children do not depend on the random values.

// File: rtl/scm_pkg.sv
package scm_pkg;

  localparam logic [31:0] SEED_FALLBACK = 32'h2545_F491;

  function automatic logic [31:0] xs32_next(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  typedef enum logic [3:0] {
    S_IDLE, S_SELA, S_GETA, S_SELB, S_GETB,
    S_XDEC, S_XCUT, S_XAPPLY, S_MUT, S_EMIT
  } scm_state_e;

endpackage

// File: rtl/scm_prng.sv
module scm_prng
  import scm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        take,
  output logic [31:0] rnd
);

  logic [31:0] state_q, state_d;
  logic        state_en;

  assign rnd      = xs32_next(state_q);
  assign state_en = load | take;

  always_comb begin
    state_d = state_q;
    if (load)      state_d = (seed == 32'd0) ? SEED_FALLBACK : seed;
    else if (take) state_d = rnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SEED_FALLBACK;
    else if (state_en) state_q <= state_d;
  end

  // R2: a zero state would lock the generator
  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 32'd0);

endmodule

// File: rtl/scm_selector.sv
module scm_selector #(
  parameter int POP_SIZE   = 8,
  parameter int FIT_W      = 8,
  parameter int RATE_W     = 16,
  parameter int SEL_METHOD = 1,
  localparam int IDX_W     = $clog2(POP_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       rnd,
  output logic              take,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [FIT_W-1:0]  rd_fit,
  output logic              done,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(POP_SIZE - 1);

  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign done = done_q;
  assign idx  = idx_q;

  generate
    if (SEL_METHOD == 1) begin : g_tour
      typedef enum logic [2:0] {T_IDLE, T_DRAW_I, T_DRAW_J, T_READ_I, T_READ_J} tstate_e;
      tstate_e          st_q, st_d;
      logic [IDX_W-1:0] cand_i_q, cand_i_d, cand_j_q, cand_j_d;
      logic [FIT_W-1:0] fit_i_q, fit_i_d;
      logic             j_wins;

      assign j_wins = (rd_fit > fit_i_q) || ((rd_fit == fit_i_q) && (cand_j_q < cand_i_q));

      always_comb begin
        st_d     = st_q;
        cand_i_d = cand_i_q;
        cand_j_d = cand_j_q;
        fit_i_d  = fit_i_q;
        idx_d    = idx_q;
        done_d   = 1'b0;
        take     = 1'b0;
        rd_addr  = '0;
        case (st_q)
          T_IDLE:   if (start) st_d = T_DRAW_I;
          T_DRAW_I: begin
            take = 1'b1; cand_i_d = rnd[IDX_W-1:0]; st_d = T_DRAW_J;
          end
          T_DRAW_J: begin
            take = 1'b1; cand_j_d = rnd[IDX_W-1:0]; st_d = T_READ_I;
          end
          T_READ_I: begin
            rd_addr = cand_i_q; fit_i_d = rd_fit; st_d = T_READ_J;
          end
          T_READ_J: begin
            rd_addr = cand_j_q;
            idx_d   = j_wins ? cand_j_q : cand_i_q;
            done_d  = 1'b1;
            st_d    = T_IDLE;
          end
          default:  st_d = T_IDLE;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q     <= T_IDLE;
          cand_i_q <= '0;
          cand_j_q <= '0;
          fit_i_q  <= '0;
          idx_q    <= '0;
          done_q   <= 1'b0;
        end else begin
          st_q   <= st_d;
          done_q <= done_d;
          if (st_q == T_DRAW_I) cand_i_q <= cand_i_d;
          if (st_q == T_DRAW_J) cand_j_q <= cand_j_d;
          if (st_q == T_READ_I) fit_i_q  <= fit_i_d;
          if (st_q == T_READ_J) idx_q    <= idx_d;
        end
      end
    end else begin : g_roul
      localparam int TOT_W = FIT_W + IDX_W;
      typedef enum logic [1:0] {W_IDLE, W_SUM, W_DRAW, W_SCAN} wstate_e;
      wstate_e             st_q, st_d;
      logic [IDX_W-1:0]    cnt_q, cnt_d;
      logic [TOT_W-1:0]    total_q, total_d, acc_q, acc_d, target_q, target_d, acc_n;
      logic [RATE_W+TOT_W-1:0] prod;
      logic                hit;

      assign prod  = {{TOT_W{1'b0}}, rnd[RATE_W-1:0]} * {{RATE_W{1'b0}}, total_q};
      assign acc_n = acc_q + TOT_W'(rd_fit);
      assign hit   = (target_q < acc_n) || (cnt_q == LAST);

      always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        total_d  = total_q;
        acc_d    = acc_q;
        target_d = target_q;
        idx_d    = idx_q;
        done_d   = 1'b0;
        take     = 1'b0;
        rd_addr  = '0;
        case (st_q)
          W_IDLE: if (start) begin
            cnt_d = '0; total_d = '0; st_d = W_SUM;
          end
          W_SUM: begin
            rd_addr = cnt_q;
            total_d = total_q + TOT_W'(rd_fit);
            if (cnt_q == LAST) st_d = W_DRAW;
            else               cnt_d = cnt_q + 1'b1;
          end
          W_DRAW: begin
            take     = 1'b1;
            target_d = prod[RATE_W +: TOT_W];
            cnt_d    = '0;
            acc_d    = '0;
            st_d     = W_SCAN;
          end
          W_SCAN: begin
            rd_addr = cnt_q;
            acc_d   = acc_n;
            if (hit) begin
              idx_d = cnt_q; done_d = 1'b1; st_d = W_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: st_d = W_IDLE;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q     <= W_IDLE;
          cnt_q    <= '0;
          total_q  <= '0;
          acc_q    <= '0;
          target_q <= '0;
          idx_q    <= '0;
          done_q   <= 1'b0;
        end else begin
          st_q   <= st_d;
          done_q <= done_d;
          cnt_q  <= cnt_d;
          if (st_q != W_IDLE) begin
            total_q  <= total_d;
            acc_q    <= acc_d;
            target_q <= target_d;
            idx_q    <= idx_d;
          end else if (start) begin
            total_q <= total_d;
          end
        end
      end
    end
  endgenerate

  // R3: one completion per request, never stretched
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/scm_crossover.sv
module scm_crossover #(
  parameter int CHROM_W  = 16,
  parameter int NUM_CUTS = 2,
  localparam int CUT_W   = $clog2(CHROM_W)
) (
  input  logic                               fire,
  input  logic [CHROM_W-1:0]                 par_a,
  input  logic [CHROM_W-1:0]                 par_b,
  input  logic [NUM_CUTS-1:0][CUT_W-1:0]     cuts,
  output logic [CHROM_W-1:0]                 child_a,
  output logic [CHROM_W-1:0]                 child_b
);

  localparam logic [CHROM_W-1:0] ONE = CHROM_W'(1);

  logic [NUM_CUTS:0][CHROM_W-1:0] mask_acc;
  logic [CHROM_W-1:0]             mask;

  assign mask_acc[0] = '0;

  generate
    for (genvar k = 0; k < NUM_CUTS; k++) begin : g_cut
      assign mask_acc[k+1] = mask_acc[k] ^ ((ONE << cuts[k]) - ONE);
    end
  endgenerate

  assign mask    = mask_acc[NUM_CUTS];
  assign child_a = fire ? ((par_a & mask) | (par_b & ~mask)) : par_a;
  assign child_b = fire ? ((par_b & mask) | (par_a & ~mask)) : par_b;

endmodule

// File: rtl/scm_mutator.sv
module scm_mutator #(
  parameter int CHROM_W = 16,
  parameter int RATE_W  = 16,
  localparam int BIT_W  = $clog2(CHROM_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CHROM_W-1:0] init,
  input  logic               step,
  input  logic [BIT_W-1:0]   bit_sel,
  input  logic [RATE_W-1:0]  rnd_part,
  input  logic [RATE_W-1:0]  rate,
  output logic [CHROM_W-1:0] word
);

  localparam logic [CHROM_W-1:0] ONE = CHROM_W'(1);

  logic [CHROM_W-1:0] word_q, word_d;
  logic               flip, word_en;

  assign flip    = step && (rnd_part < rate);
  assign word_en = load | step;
  assign word    = word_q;

  always_comb begin
    word_d = word_q;
    if (load)      word_d = init;
    else if (flip) word_d = word_q ^ (ONE << bit_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  // R8: a zero rate never flips a bit
  a_r8_zero_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && rate == '0) |=> $stable(word_q));

endmodule

// File: rtl/scm_pair_unit.sv
module scm_pair_unit
  import scm_pkg::*;
#(
  parameter int CHROM_W    = 16,
  parameter int FIT_W      = 8,
  parameter int POP_SIZE   = 8,
  parameter int RATE_W     = 16,
  parameter int NUM_CUTS   = 2,
  parameter int SEL_METHOD = 1,
  localparam int IDX_W     = $clog2(POP_SIZE),
  localparam int CUT_W     = $clog2(CHROM_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  input  logic               seed_load,
  input  logic [31:0]        seed,
  input  logic [RATE_W-1:0]  xover_rate,
  input  logic [RATE_W-1:0]  mut_rate,
  output logic [IDX_W-1:0]   rd_addr,
  input  logic [CHROM_W-1:0] rd_chrom,
  input  logic [FIT_W-1:0]   rd_fit,
  output logic               off_valid,
  output logic [IDX_W-1:0]   off_idx_a,
  output logic [IDX_W-1:0]   off_idx_b,
  output logic [CHROM_W-1:0] off_child_a,
  output logic [CHROM_W-1:0] off_child_b
);

  localparam int CNT_W = (CUT_W > $clog2(NUM_CUTS + 1)) ? CUT_W : $clog2(NUM_CUTS + 1);
  localparam logic [CNT_W-1:0] CUT_LAST = CNT_W'(NUM_CUTS - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(CHROM_W - 1);

  scm_state_e                       state_q, state_d;
  logic [IDX_W-1:0]                 idx_a_q, idx_a_d, idx_b_q, idx_b_d;
  logic [CHROM_W-1:0]               par_a_q, par_a_d, par_b_q, par_b_d;
  logic                             xfire_q, xfire_d;
  logic [NUM_CUTS-1:0][CUT_W-1:0]   cuts_q, cuts_d;
  logic [CNT_W-1:0]                 cnt_q, cnt_d;

  logic [31:0]        rnd;
  logic               take, sel_start, sel_take, sel_done, mut_load, mut_step;
  logic [IDX_W-1:0]   sel_rd_addr, sel_idx;
  logic [CHROM_W-1:0] x_child_a, x_child_b;
  logic [1:0][CHROM_W-1:0] mut_word;
  logic [1:0][CHROM_W-1:0] mut_init;

  scm_prng u_prng (
    .clk  (clk),
    .rst_n(rst_n),
    .load (seed_load),
    .seed (seed),
    .take (take),
    .rnd  (rnd)
  );

  scm_selector #(
    .POP_SIZE  (POP_SIZE),
    .FIT_W     (FIT_W),
    .RATE_W    (RATE_W),
    .SEL_METHOD(SEL_METHOD)
  ) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sel_start),
    .rnd    (rnd),
    .take   (sel_take),
    .rd_addr(sel_rd_addr),
    .rd_fit (rd_fit),
    .done   (sel_done),
    .idx    (sel_idx)
  );

  scm_crossover #(
    .CHROM_W (CHROM_W),
    .NUM_CUTS(NUM_CUTS)
  ) u_xover (
    .fire   (xfire_q),
    .par_a  (par_a_q),
    .par_b  (par_b_q),
    .cuts   (cuts_q),
    .child_a(x_child_a),
    .child_b(x_child_b)
  );

  assign mut_init[0] = x_child_a;
  assign mut_init[1] = x_child_b;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_mut
      scm_mutator #(
        .CHROM_W(CHROM_W),
        .RATE_W (RATE_W)
      ) u_mut (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mut_load),
        .init    (mut_init[g]),
        .step    (mut_step),
        .bit_sel (cnt_q[CUT_W-1:0]),
        .rnd_part(rnd[g*RATE_W +: RATE_W]),
        .rate    (mut_rate),
        .word    (mut_word[g])
      );
    end
  endgenerate

  always_comb begin
    state_d   = state_q;
    idx_a_d   = idx_a_q;
    idx_b_d   = idx_b_q;
    par_a_d   = par_a_q;
    par_b_d   = par_b_q;
    xfire_d   = xfire_q;
    cuts_d    = cuts_q;
    cnt_d     = cnt_q;
    sel_start = 1'b0;
    take      = 1'b0;
    mut_load  = 1'b0;
    mut_step  = 1'b0;
    rd_addr   = '0;
    case (state_q)
      S_IDLE: if (start) begin
        sel_start = 1'b1;
        state_d   = S_SELA;
      end
      S_SELA: begin
        rd_addr = sel_rd_addr;
        take    = sel_take;
        if (sel_done) begin
          idx_a_d = sel_idx;
          state_d = S_GETA;
        end
      end
      S_GETA: begin
        rd_addr   = idx_a_q;
        par_a_d   = rd_chrom;
        sel_start = 1'b1;
        state_d   = S_SELB;
      end
      S_SELB: begin
        rd_addr = sel_rd_addr;
        take    = sel_take;
        if (sel_done) begin
          idx_b_d = sel_idx;
          state_d = S_GETB;
        end
      end
      S_GETB: begin
        rd_addr = idx_b_q;
        par_b_d = rd_chrom;
        state_d = S_XDEC;
      end
      S_XDEC: begin
        take    = 1'b1;
        xfire_d = rnd[RATE_W-1:0] < xover_rate;
        cnt_d   = '0;
        state_d = S_XCUT;
      end
      S_XCUT: begin
        take = 1'b1;
        for (int k = 0; k < NUM_CUTS; k++) begin
          if (cnt_q == CNT_W'(k)) cuts_d[k] = rnd[CUT_W-1:0];
        end
        if (cnt_q == CUT_LAST) begin
          cnt_d   = '0;
          state_d = S_XAPPLY;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_XAPPLY: begin
        mut_load = 1'b1;
        cnt_d    = '0;
        state_d  = S_MUT;
      end
      S_MUT: begin
        take     = 1'b1;
        mut_step = 1'b1;
        if (cnt_q == BIT_LAST) state_d = S_EMIT;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      S_EMIT:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_a_q <= '0;
      idx_b_q <= '0;
      par_a_q <= '0;
      par_b_q <= '0;
      xfire_q <= 1'b0;
      cuts_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == S_SELA) idx_a_q <= idx_a_d;
      if (state_q == S_SELB) idx_b_q <= idx_b_d;
      if (state_q == S_GETA) par_a_q <= par_a_d;
      if (state_q == S_GETB) par_b_q <= par_b_d;
      if (state_q == S_XDEC) xfire_q <= xfire_d;
      if (state_q == S_XCUT) cuts_q  <= cuts_d;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign off_valid   = (state_q == S_EMIT);
  assign off_idx_a   = idx_a_q;
  assign off_idx_b   = idx_b_q;
  assign off_child_a = mut_word[0];
  assign off_child_b = mut_word[1];

  // R9: offspring beat lasts exactly one cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |=> !off_valid);

  // R9: a start while busy does not end or restart the operation
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !off_valid) |=> busy);

  // R7: exchange only moves bits between the two children
  a_r7_exchange_conserves: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_XAPPLY) |->
      (((x_child_a ^ x_child_b) == (par_a_q ^ par_b_q)) &&
       ((x_child_a & x_child_b) == (par_a_q & par_b_q))));

  // R6: without a crossover decision the parents pass through
  a_r6_no_fire_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_XAPPLY && !xfire_q) |->
      (x_child_a == par_a_q && x_child_b == par_b_q));

endmodule

// File: tb/scm_pair_unit_tb.sv
module scm_pair_unit_tb_top;

  localparam int CW = 16;
  localparam int FW = 8;
  localparam int PS = 8;
  localparam int RW = 16;
  localparam logic [31:0] FALLBACK = 32'h2545_F491;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic seed_load = 1'b0;
  logic [31:0] seed = '0;
  logic [RW-1:0] xr = '0, mr = '0;

  logic [CW-1:0] chrom [PS];
  logic [FW-1:0] fitm  [PS];

  logic          busy_t, valid_t, busy_r, valid_r;
  logic [2:0]    addr_t, addr_r, ia_t, ib_t, ia_r, ib_r;
  logic [CW-1:0] ca_t, cb_t, ca_r, cb_r;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  scm_pair_unit #(.NUM_CUTS(2), .SEL_METHOD(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_t),
    .seed_load(seed_load), .seed(seed), .xover_rate(xr), .mut_rate(mr),
    .rd_addr(addr_t), .rd_chrom(chrom[addr_t]), .rd_fit(fitm[addr_t]),
    .off_valid(valid_t), .off_idx_a(ia_t), .off_idx_b(ib_t),
    .off_child_a(ca_t), .off_child_b(cb_t));

  scm_pair_unit #(.NUM_CUTS(1), .SEL_METHOD(0)) dut_r (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_r),
    .seed_load(seed_load), .seed(seed), .xover_rate(xr), .mut_rate(mr),
    .rd_addr(addr_r), .rd_chrom(chrom[addr_r]), .rd_fit(fitm[addr_r]),
    .off_valid(valid_r), .off_idx_a(ia_r), .off_idx_b(ib_r),
    .off_child_a(ca_r), .off_child_b(cb_r));

  // ---------------- reference model ----------------
  logic [31:0] s_t, s_r;

  function automatic logic [31:0] step32(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic draw(inout logic [31:0] s, output logic [31:0] v);
    s = step32(s);
    v = s;
  endtask

  task automatic pick(input int meth, inout logic [31:0] s, output int w);
    logic [31:0] v;
    if (meth == 1) begin
      int i, j;
      draw(s, v); i = int'(v[2:0]);
      draw(s, v); j = int'(v[2:0]);
      if (fitm[j] > fitm[i] || (fitm[j] == fitm[i] && j < i)) w = j;
      else w = i;
    end else begin
      longint tot, tgt, acc;
      tot = 0;
      for (int k = 0; k < PS; k++) tot += longint'(fitm[k]);
      draw(s, v);
      tgt = (longint'(v[15:0]) * tot) >> 16;
      acc = 0;
      w = PS - 1;
      for (int k = 0; k < PS; k++) begin
        acc += longint'(fitm[k]);
        if (tgt < acc) begin w = k; break; end
      end
    end
  endtask

  task automatic model_op(input int meth, input int ncut, inout logic [31:0] s,
                          output int ia, output int ib,
                          output logic [CW-1:0] ca, output logic [CW-1:0] cb);
    logic [31:0] v;
    logic [CW-1:0] pa, pb, mask;
    logic fire;
    pick(meth, s, ia);
    pa = chrom[ia];
    pick(meth, s, ib);
    pb = chrom[ib];
    draw(s, v);
    fire = v[15:0] < xr;
    mask = '0;
    for (int k = 0; k < ncut; k++) begin
      draw(s, v);
      mask = mask ^ ((16'd1 << v[3:0]) - 16'd1);
    end
    if (fire) begin
      ca = (pa & mask) | (pb & ~mask);
      cb = (pb & mask) | (pa & ~mask);
    end else begin
      ca = pa;
      cb = pb;
    end
    for (int b = 0; b < CW; b++) begin
      draw(s, v);
      if (v[15:0]  < mr) ca[b] = ~ca[b];
      if (v[31:16] < mr) cb[b] = ~cb[b];
    end
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic load_seed(input logic [31:0] sd);
    @(negedge clk) begin seed_load = 1'b1; seed = sd; end
    @(negedge clk) seed_load = 1'b0;
    s_t = (sd == 0) ? FALLBACK : sd;
    s_r = s_t;
  endtask

  logic [2:0]    g_ia_t, g_ib_t, g_ia_r, g_ib_r;
  logic [CW-1:0] g_ca_t, g_cb_t, g_ca_r, g_cb_r;

  task automatic run_op();
    pulse_start();
    fork
      begin
        while (!valid_t) @(negedge clk);
        g_ia_t = ia_t; g_ib_t = ib_t; g_ca_t = ca_t; g_cb_t = cb_t;
      end
      begin
        while (!valid_r) @(negedge clk);
        g_ia_r = ia_r; g_ib_r = ib_r; g_ca_r = ca_r; g_cb_r = cb_r;
      end
    join
    @(negedge clk);
  endtask

  task automatic check_model(input string req);
    int ia, ib;
    logic [CW-1:0] ca, cb;
    model_op(1, 2, s_t, ia, ib, ca, cb);
    chk(req, "tour idx_a", 32'(g_ia_t), 32'(ia));
    chk(req, "tour idx_b", 32'(g_ib_t), 32'(ib));
    chk(req, "tour child_a", 32'(g_ca_t), 32'(ca));
    chk(req, "tour child_b", 32'(g_cb_t), 32'(cb));
    model_op(0, 1, s_r, ia, ib, ca, cb);
    chk(req, "roul idx_a", 32'(g_ia_r), 32'(ia));
    chk(req, "roul idx_b", 32'(g_ib_r), 32'(ib));
    chk(req, "roul child_a", 32'(g_ca_r), 32'(ca));
    chk(req, "roul child_b", 32'(g_cb_r), 32'(cb));
  endtask

  task automatic fill_random();
    for (int k = 0; k < PS; k++) begin
      chrom[k] = CW'($urandom);
      fitm[k]  = FW'($urandom);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd1357));
    fill_random();
    s_t = FALLBACK;
    s_r = FALLBACK;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "busy_t", 32'(busy_t), 0);
    chk("R1", "valid_t", 32'(valid_t), 0);
    chk("R1", "busy_r", 32'(busy_r), 0);
    chk("R1", "valid_r", 32'(valid_r), 0);

    // R1 R2 R3: first op from the reset state, zero rates
    xr = '0; mr = '0;
    run_op();
    check_model("R1/R2/R3");
    // R6 R8: zero rates give the selected parents unchanged
    chk("R6", "tour child_a copy", 32'(g_ca_t), 32'(chrom[g_ia_t]));
    chk("R8", "tour child_b copy", 32'(g_cb_t), 32'(chrom[g_ib_t]));
    chk("R6", "roul child_a copy", 32'(g_ca_r), 32'(chrom[g_ia_r]));

    // R2: zero seed falls back to the constant
    load_seed(32'd0);
    xr = 16'h8000; mr = 16'h1000;
    run_op();
    check_model("R2");

    // R5: single nonzero fitness dominates roulette
    load_seed(32'hCAFE_0001);
    for (int k = 0; k < PS; k++) fitm[k] = '0;
    fitm[5] = 8'd10;
    run_op();
    chk("R5", "roul one-hot idx_a", 32'(g_ia_r), 5);
    chk("R5", "roul one-hot idx_b", 32'(g_ib_r), 5);
    check_model("R5");

    // R5: all-zero fitness selects the last index
    fitm[5] = '0;
    run_op();
    chk("R5", "roul zero idx_a", 32'(g_ia_r), PS - 1);
    chk("R5", "roul zero idx_b", 32'(g_ib_r), PS - 1);
    check_model("R5");

    // R4: equal fitness, lower index wins ties
    for (int k = 0; k < PS; k++) fitm[k] = 8'd50;
    run_op();
    check_model("R4");

    // R7: forced crossover without mutation conserves bits
    fill_random();
    xr = 16'hFFFF; mr = '0;
    for (int n = 0; n < 4; n++) begin
      run_op();
      chk("R7", "tour xor", 32'(g_ca_t ^ g_cb_t), 32'(chrom[g_ia_t] ^ chrom[g_ib_t]));
      chk("R7", "tour and", 32'(g_ca_t & g_cb_t), 32'(chrom[g_ia_t] & chrom[g_ib_t]));
      chk("R7", "roul xor", 32'(g_ca_r ^ g_cb_r), 32'(chrom[g_ia_r] ^ chrom[g_ib_r]));
      check_model("R7");
    end

    // R8: near-certain mutation, no crossover
    xr = '0; mr = 16'hFFFF;
    run_op();
    check_model("R8");

    // R9: start while busy is ignored, one beat only
    xr = 16'h4000; mr = 16'h0800;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    fork
      begin
        while (!valid_t) @(negedge clk);
        g_ia_t = ia_t; g_ib_t = ib_t; g_ca_t = ca_t; g_cb_t = cb_t;
        @(negedge clk);
        chk("R9", "tour valid one cycle", 32'(valid_t), 0);
      end
      begin
        while (!valid_r) @(negedge clk);
        g_ia_r = ia_r; g_ib_r = ib_r; g_ca_r = ca_r; g_cb_r = cb_r;
        @(negedge clk);
        chk("R9", "roul valid one cycle", 32'(valid_r), 0);
      end
    join
    repeat (10) @(negedge clk);
    chk("R9", "tour idle after beat", 32'(busy_t), 0);
    chk("R9", "roul idle after beat", 32'(busy_r), 0);
    check_model("R9");
    run_op();
    check_model("R9/R3 no extra draws");

    // R3 R4 R5 R6 R7 R8: random traffic
    for (int n = 0; n < 40; n++) begin
      fill_random();
      if (n % 10 == 0) load_seed($urandom);
      xr = RW'($urandom);
      mr = RW'($urandom_range(0, 16'h3000));
      run_op();
      check_model("R3/R4/R5/R6/R7/R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule